// File: doc/BRIEF.md
# Shift-Switch Unary Modulo Adder Chain

This block sums a vector of single-bit addends into a one-hot unary counter without using a binary adder. The block has M identical cells connected in a line, and a W-bit one-hot word passes through them. A cell whose addend bit is high rotates the word up by one position, moving the top bit round to the bottom. A cell whose addend bit is low passes the word on unchanged. The word that leaves the last cell is the unary residue of the start value plus the number of set addends, modulo W.

A cell raises its wrap flag when it rotates a word whose top bit is set. Two wraps can never fall within W consecutive cells, so the block ORs the flags of each group of W cells into one bit without losing information. The result is a distributed code of ceil(M/W) bits, and its population count is the number of complete wraps.

A parameter selects a registered variant, which models one broadcast step. In that variant both results are captured on the clock edge at which the valid strobe is high, and an output strobe marks them one cycle later. With the parameter cleared, the outputs follow the inputs combinationally.

Top module: `ssw_chain_top`

## Requirements
- R1: A value z in 0..W-1 is encoded over W bits by setting only bit z (bit 0 is the least significant), so zero is the word with only bit 0 set.
- R2: For a one-hot start value s and addend vector a, resUnary encodes (s + number of ones in a) mod W.
- R3: The number of ones in wrapDist equals floor((s + number of ones in a) / W).
- R4: Cells are numbered 0 to M-1 from the start end. Cell j wraps when its addend bit is 1 and the word entering it has bit W-1 set. Bit g of wrapDist is the OR of the wrap flags of cells g*W to g*W+W-1.
- R5: When M is not a multiple of W, the top bit of wrapDist covers only the cells that exist, M-(G-1)*W of them.
- R6: In registered mode, the results for the inputs present at a rising clock edge with inValid high appear on resUnary and wrapDist after that edge, and outValid is high for the following cycle.
- R7: In registered mode, an edge with inValid low leaves resUnary and wrapDist unchanged, even when the inputs change, and drives outValid low.
- R8: While reset is active, resUnary encodes zero, wrapDist is all zeros and outValid is low.
- R9: With every addend set and start W-1, the result is the largest possible sum: resUnary encodes (W-1+M) mod W and wrapDist shows every wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Capture strobe for the registered variant |
| startUnary | input | W | One-hot start value |
| addBits | input | M | Addend bits, bit j feeds cell j |
| resUnary | output | W | One-hot residue of the total modulo W |
| wrapDist | output | ceil(M/W) | Distributed wrap count, one bit per group of W cells |
| outValid | output | 1 | Results valid strobe |

## Verification
The bench sets only the top bit of the start word and then walks a single addend across every cell. This shows whether the wrap lands in the right group bit and whether the rotation direction is correct: a chain that rotates downward, or a group that is misaligned by one cell, sets the wrong bit of wrapDist. A test with every addend set at the top start value drives the maximum number of wraps, including one in the short final group. A design that drops that group, or that flags the wrap on the wrong cell boundary, loses a count. Hold tests change the inputs while the strobe is low, which exposes a register that captures on every edge.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
  typedef struct packed {
    logic capture;
  } ssw_strobe_t;

  function automatic int groupCount(input int m, input int w);
    return (m + w - 1) / w;
  endfunction
endpackage

// File: rtl/ssw_cell.sv
module ssw_cell #(
  parameter int W = 4
) (
  input  logic [W-1:0] unaryIn,
  input  logic         addBit,
  output logic [W-1:0] unaryOut,
  output logic         rotBit
);
  logic [W-1:0] rotated;
  assign rotated  = {unaryIn[W-2:0], unaryIn[W-1]};
  assign unaryOut = addBit ? rotated : unaryIn;
  assign rotBit   = addBit & unaryIn[W-1];
endmodule

// File: rtl/ssw_ctrl.sv
module ssw_ctrl #(
  parameter bit REGISTERED = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output ssw_pkg::ssw_strobe_t strobe,
  output logic                outValid
);
  assign strobe.capture = inValid;

  generate
    if (REGISTERED) begin : g_reg
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;

      // R6: a capture is announced one cycle later
      p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);
      // R7: no strobe without a capture
      p_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/ssw_datapath.sv
module ssw_datapath #(
  parameter int W = 4,
  parameter int M = 18,
  parameter bit REGISTERED = 1'b1,
  localparam int G = ssw_pkg::groupCount(M, W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ssw_pkg::ssw_strobe_t strobe,
  input  logic [W-1:0]         startUnary,
  input  logic [M-1:0]         addBits,
  output logic [W-1:0]         resUnary,
  output logic [G-1:0]         wrapDist
);
  localparam logic [W-1:0] ZERO_CODE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] stage [M+1];
  logic [M-1:0] rotBits;
  logic [G-1:0] wrapComb;

  assign stage[0] = startUnary;

  generate
    for (genvar j = 0; j < M; j++) begin : g_cell
      ssw_cell #(.W(W)) u_cell (
        .unaryIn (stage[j]),
        .addBit  (addBits[j]),
        .unaryOut(stage[j+1]),
        .rotBit  (rotBits[j])
      );
    end

    for (genvar g = 0; g < G; g++) begin : g_group
      localparam int LO = g * W;
      localparam int HI = (g * W + W - 1 < M) ? g * W + W - 1 : M - 1;
      assign wrapComb[g] = |rotBits[HI:LO];

      // R4: at most one wrap per group, so the OR loses nothing
      p_sparse_group_r4: assert property (@(posedge clk) disable iff (!rstN)
        $onehot(startUnary) |-> $onehot0(rotBits[HI:LO]));
    end

    if (REGISTERED) begin : g_reg
      logic [W-1:0] resQ;
      logic [G-1:0] distQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          resQ  <= ZERO_CODE;
          distQ <= '0;
        end else if (strobe.capture) begin
          resQ  <= stage[M];
          distQ <= wrapComb;
        end
      end
      assign resUnary = resQ;
      assign wrapDist = distQ;

      // R7: outputs hold between captures
      p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.capture |=> ($stable(resUnary) && $stable(wrapDist)));
    end else begin : g_comb
      assign resUnary = stage[M];
      assign wrapDist = wrapComb;
    end
  endgenerate

  // R2: the chain keeps a one-hot word one-hot
  p_residue_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(startUnary) |-> $onehot(stage[M]));
endmodule

// File: rtl/ssw_chain_top.sv
module ssw_chain_top #(
  parameter int W = 4,
  parameter int M = 18,
  parameter bit REGISTERED = 1'b1,
  localparam int G = ssw_pkg::groupCount(M, W)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [W-1:0] startUnary,
  input  logic [M-1:0] addBits,
  output logic [W-1:0] resUnary,
  output logic [G-1:0] wrapDist,
  output logic         outValid
);
  ssw_pkg::ssw_strobe_t strobe;

  ssw_ctrl #(.REGISTERED(REGISTERED)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  ssw_datapath #(.W(W), .M(M), .REGISTERED(REGISTERED)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startUnary(startUnary),
    .addBits   (addBits),
    .resUnary  (resUnary),
    .wrapDist  (wrapDist)
  );
endmodule

// File: tb/sim_ssw_chain_top.sv
module sim_ssw_chain_top;
  localparam int W = 4;
  localparam int M = 18;
  localparam int G = (M + W - 1) / W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [W-1:0] startUnary = 1;
  logic [M-1:0] addBits = '0;
  logic [W-1:0] resUnary;
  logic [G-1:0] wrapDist;
  logic outValid;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ssw_chain_top #(.W(W), .M(M), .REGISTERED(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .startUnary(startUnary),
    .addBits(addBits), .resUnary(resUnary), .wrapDist(wrapDist), .outValid(outValid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] encode(input int z);
    logic [W-1:0] r;
    r = '0;
    r[z] = 1'b1;
    return r;
  endfunction

  // Walks the cells in order and records every wrap (R4)
  task automatic model(input int start, input logic [M-1:0] bits,
                       output logic [W-1:0] expRes, output logic [G-1:0] expDist);
    int v;
    v = start;
    expDist = '0;
    for (int j = 0; j < M; j++) begin
      if (bits[j]) begin
        if (v == W - 1) expDist[j / W] = 1'b1;
        v = (v + 1) % W;
      end
    end
    expRes = encode(v);
  endtask

  // Drive at negedge, capture at posedge, check at next negedge
  task automatic applyAndCheck(input int start, input logic [M-1:0] bits, input string req);
    logic [W-1:0] expRes;
    logic [G-1:0] expDist;
    int total;
    model(start, bits, expRes, expDist);
    total = start + $countones(bits);
    startUnary = encode(start);
    addBits = bits;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(resUnary == expRes, req, "residue R2", 64'(resUnary), 64'(expRes));
    check(resUnary == encode(total % W), req, "residue formula R2", 64'(resUnary),
          64'(encode(total % W)));
    check($countones(wrapDist) == total / W, req, "wrap count R3",
          64'($countones(wrapDist)), 64'(total / W));
    check(wrapDist == expDist, req, "wrap pattern R4", 64'(wrapDist), 64'(expDist));
    check(outValid == 1'b1, req, "outValid R6", 64'(outValid), 64'd1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(resUnary == {{(W-1){1'b0}}, 1'b1}, "R8", "reset residue is zero code R1",
          64'(resUnary), 64'd1);
    check(wrapDist == '0, "R8", "reset wrapDist", 64'(wrapDist), 64'd0);
    check(outValid == 1'b0, "R8", "reset outValid", 64'(outValid), 64'd0);
  endtask

  task automatic testZeros();
    for (int s = 0; s < W; s++) applyAndCheck(s, '0, "R1");
  endtask

  task automatic testAllOnes();
    applyAndCheck(W - 1, '1, "R9");
    check(wrapDist == '1, "R9", "every group wraps", 64'(wrapDist), 64'h1f);
    check(resUnary == encode((W - 1 + M) % W), "R9", "max residue", 64'(resUnary),
          64'(encode((W - 1 + M) % W)));
  endtask

  task automatic testWalking();
    for (int j = 0; j < M; j++) begin
      logic [M-1:0] b;
      b = '0;
      b[j] = 1'b1;
      applyAndCheck(W - 1, b, "R4");
      check(wrapDist == G'(1 << (j / W)), "R4", "single wrap group", 64'(wrapDist),
            64'(1 << (j / W)));
    end
  endtask

  task automatic testPartial();
    logic [M-1:0] b;
    b = '0;
    b[M-2] = 1'b1;
    b[M-1] = 1'b1;
    applyAndCheck(2, b, "R5");
    check(wrapDist == G'(1 << (G - 1)), "R5", "short last group", 64'(wrapDist),
          64'(1 << (G - 1)));
  endtask

  task automatic testRandom();
    for (int i = 0; i < 40; i++) begin
      logic [M-1:0] b;
      b = M'($urandom);
      applyAndCheck(int'($urandom % W), b, "R3");
    end
  endtask

  task automatic testHold();
    logic [W-1:0] heldRes;
    logic [G-1:0] heldDist;
    applyAndCheck(1, 18'h2ab35, "R6");
    heldRes = resUnary;
    heldDist = wrapDist;
    for (int k = 0; k < 3; k++) begin
      startUnary = encode(k);
      addBits = M'($urandom) | 1;
      inValid = 1'b0;
      @(negedge clk);
      check(resUnary == heldRes, "R7", "residue held", 64'(resUnary), 64'(heldRes));
      check(wrapDist == heldDist, "R7", "wrapDist held", 64'(wrapDist), 64'(heldDist));
      check(outValid == 1'b0, "R7", "outValid low", 64'(outValid), 64'd0);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testZeros();
    testAllOnes();
    testWalking();
    testPartial();
    testRandom();
    testHold();
    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule